// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges four reset requests into a single active-low system reset and keeps a record of which request caused the most recent reset. The requests are an active-low external reset pin that has already been synchronised, a one-cycle pulse from a missing-clock timer, the digital output of a voltage comparator, and a "supply at or below threshold" status from a supply monitor. The comparator, the supply monitor and any pin filtering are outside the block and reach it only as digital inputs.

Software sees two 8-bit registers on a small read/write bus. Address 0 is the source register. In this register, writing a bit sets the enable for a source, and reading the same bit returns whether that source caused the last reset. Address 1 is the monitor control register. It holds the monitor's on switch and a live status bit.

A separate power-on input clears every register bit. An ordinary system reset keeps all enables, so software configuration survives it. The system reset output stays low while any request is active and for a fixed stretch after the last request goes away. It is released on a clock edge.

The sequencer has three named states:
- `ST_RUN`: normal operation.
- `ST_HOLD`: at least one request is active.
- `ST_STRETCH`: the release countdown is running.

It has these named transitions:
- *trip*: `ST_RUN` to `ST_HOLD` on any request. The winning source is captured at this point.
- *quiet*: `ST_HOLD` to `ST_STRETCH` when no request is active.
- *retrip*: `ST_STRETCH` back to `ST_HOLD` when a request appears during the countdown.
- *expire*: `ST_STRETCH` to `ST_RUN` when the countdown ends.

The power-on input forces `ST_HOLD`.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `por_n` is low, every register bit is cleared and `sys_rst_n` is low. After `por_n` rises, `sys_rst_n` stays low for 16 further cycles.
- R2: If `ext_pin_n` is low at a clock edge, `sys_rst_n` is low after that edge. When that reset starts from `ST_RUN`, bit 0 of the source register reads 1.
- R3: Writing bit 2 of the source register enables (1) or disables (0) the missing-clock source. A `clk_missing` pulse resets the system only when this source is enabled. Bit 2 reads 1 only after a missing-clock reset.
- R4: Writing bit 5 of the source register enables the comparator source. When enabled, `cmp_out` = 0 requests a reset. Bit 5 reads 1 only after a comparator reset.
- R5: Writing bit 1 of the source register selects the supply source. `sup_low` = 1 causes a reset only if this bit is 1 and bit 7 of the control register (monitor on) is also 1. Bit 1 reads 1 only after a supply reset.
- R6: Bit 6 of the control register always reads the inverse of `sup_low` (1 = supply above threshold). Bits 5..0 of the control register read 0, and writes to them are ignored.
- R7: On each trip, exactly one source flag is set and all others are cleared. When several sources request at once, the winner is chosen in the order pin, supply, missing clock, comparator.
- R8: `sys_rst_n` returns high exactly 16 cycles after the first edge at which no request is active. A request seen during the countdown restarts the hold.
- R9: A system reset leaves all enables unchanged, and bus writes made while `sys_rst_n` is low are ignored.
- R10: `rdata` shows the source register when `addr` = 0 and the control register when `addr` = 1, with no delay. Writes take effect at the clock edge where `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| ext_pin_n | input | 1 | Synchronised external reset pin, active low |
| clk_missing | input | 1 | One-cycle timeout pulse from the missing-clock timer |
| cmp_out | input | 1 | Comparator output; 0 requests a reset |
| sup_low | input | 1 | Supply at or below threshold |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 source, 1 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| sys_rst_n | output | 1 | Stretched system reset, active low |

## Verification
The hardest situation to reach is a trip in which all four sources request in the same cycle. Only that case shows the fixed priority and the clearing of the losing flags. To reach it, the bench first enables every source and turns the monitor on. It then changes all four request inputs at one falling edge, so the next rising edge sees them together. Repeating the trip with the winner removed each time walks down the priority order. A second hard case is a bus write that lands while the reset is low. The bench shows it was ignored by tripping the untouched source afterwards.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int REG_W      = 8;
    localparam int SRC_PIN    = 0;
    localparam int SRC_SUP    = 1;
    localparam int SRC_MCD    = 2;
    localparam int SRC_CMP    = 5;
    localparam int CTL_ON     = 7;
    localparam int CTL_STAT   = 6;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_HOLD,
        ST_STRETCH
    } rsc_state_e;

    typedef struct packed {
        logic cmp;
        logic mcd;
        logic sup;
        logic pin;
    } rsc_src_t;
endpackage

// File: rtl/rsc_prio.sv
module rsc_prio
    import rsc_pkg::*;
(
    input  rsc_src_t req,
    output rsc_src_t winner,
    output logic     any_req
);
    always_comb begin
        winner = '0;
        if (req.pin)      winner.pin = 1'b1;
        else if (req.sup) winner.sup = 1'b1;
        else if (req.mcd) winner.mcd = 1'b1;
        else if (req.cmp) winner.cmp = 1'b1;
    end

    assign any_req = |req;
endmodule

// File: rtl/rsc_seq.sv
module rsc_seq
    import rsc_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic any_req,
    output logic run,
    output logic capture,
    output logic rst_n
);
    localparam int CW = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

    rsc_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state <= ST_HOLD;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                  cnt <= '0;
        else if (state != ST_STRETCH) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:     if (any_req) nxt = ST_HOLD;
            ST_HOLD:    if (!any_req) nxt = ST_STRETCH;
            ST_STRETCH: begin
                if (any_req)          nxt = ST_HOLD;
                else if (cnt == LAST) nxt = ST_RUN;
            end
            default:    nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        run     = (state == ST_RUN);
        capture = run && any_req;
        rst_n   = run;
    end

    // R8: release only follows a cycle with no request
    a_r8_release_quiet: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_n) |-> $past(!any_req));
endmodule

// File: rtl/rsc_regs.sv
module rsc_regs
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              run,
    input  logic              capture,
    input  rsc_src_t          winner,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              sup_low,
    output logic [REG_W-1:0]  rdata,
    output logic              mcd_en,
    output logic              cmp_en,
    output logic              sup_sel,
    output logic              mon_on
);
    rsc_src_t flags;
    logic unused_wbits;

    assign unused_wbits = ^{wdata[SRC_PIN], wdata[4:3], wdata[CTL_STAT]};

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flags   <= '0;
            mcd_en  <= 1'b0;
            cmp_en  <= 1'b0;
            sup_sel <= 1'b0;
            mon_on  <= 1'b0;
        end else begin
            if (capture) flags <= winner;
            if (run && wr_en) begin
                if (!addr) begin
                    mcd_en  <= wdata[SRC_MCD];
                    cmp_en  <= wdata[SRC_CMP];
                    sup_sel <= wdata[SRC_SUP];
                end else begin
                    mon_on  <= wdata[CTL_ON];
                end
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[SRC_PIN] = flags.pin;
            rdata[SRC_SUP] = flags.sup;
            rdata[SRC_MCD] = flags.mcd;
            rdata[SRC_CMP] = flags.cmp;
        end else begin
            rdata[CTL_ON]   = mon_on;
            rdata[CTL_STAT] = !sup_low;
        end
    end

    // R7: at most one flag is ever set
    a_r7_single_flag: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(flags));
    // R5: supply flag needs monitor on, selection and low supply
    a_r5_supply_gated: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flags.sup) |-> $past(mon_on && sup_sel && sup_low));
    // R3: missing-clock flag needs its enable
    a_r3_mcd_gated: assert property (@(posedge clk) disable iff (!por_n)
        $rose(flags.mcd) |-> $past(mcd_en));
    // R9: enables frozen while reset is asserted
    a_r9_hold_enables: assert property (@(posedge clk) disable iff (!por_n)
        !run |=> $stable({mcd_en, cmp_en, sup_sel, mon_on}));
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rsc_pkg::*;
#(
    parameter int STRETCH_CYC = 16
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_pin_n,
    input  logic              clk_missing,
    input  logic              cmp_out,
    input  logic              sup_low,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              sys_rst_n
);
    rsc_src_t req, winner;
    logic any_req, run, capture;
    logic mcd_en, cmp_en, sup_sel, mon_on;

    always_comb begin
        req.pin = !ext_pin_n;
        req.sup = mon_on && sup_sel && sup_low;
        req.mcd = mcd_en && clk_missing;
        req.cmp = cmp_en && !cmp_out;
    end

    rsc_prio u_prio (
        .req     (req),
        .winner  (winner),
        .any_req (any_req)
    );

    rsc_seq #(.STRETCH_CYC(STRETCH_CYC)) u_seq (
        .clk     (clk),
        .por_n   (por_n),
        .any_req (any_req),
        .run     (run),
        .capture (capture),
        .rst_n   (sys_rst_n)
    );

    rsc_regs u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .run     (run),
        .capture (capture),
        .winner  (winner),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .sup_low (sup_low),
        .rdata   (rdata),
        .mcd_en  (mcd_en),
        .cmp_en  (cmp_en),
        .sup_sel (sup_sel),
        .mon_on  (mon_on)
    );

    // R2: a low pin forces reset after the edge
    a_r2_pin_forces: assert property (@(posedge clk) disable iff (!por_n)
        !ext_pin_n |=> !sys_rst_n);
endmodule

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_pin_n = 1'b1;
    logic       clk_missing = 1'b0;
    logic       cmp_out = 1'b1;
    logic       sup_low = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sys_rst_n;
    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    rst_src_ctrl u_rst_src_ctrl (
        .clk(clk), .por_n(por_n), .ext_pin_n(ext_pin_n), .clk_missing(clk_missing),
        .cmp_out(cmp_out), .sup_low(sup_low), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sys_rst_n(sys_rst_n)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic count_low(output int n);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (sys_rst_n) break;
            n++;
        end
    endtask

    task automatic expect_quiet(input string tag);
        int lows = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (!sys_rst_n) lows++;
        end
        check(tag, lows, 0);
    endtask

    task automatic pulse_mcd();
        @(negedge clk); clk_missing = 1'b1;
        @(negedge clk); clk_missing = 1'b0;
    endtask

    task automatic t_por();
        logic [7:0] d; int n;
        repeat (3) @(negedge clk);
        check("R1 low during power-on", sys_rst_n, 0);
        por_n = 1'b1;
        count_low(n);
        check("R1 stretch after power-on", n, 16);
        bus_read(1'b0, d); check("R1 source reg cleared", d, 8'h00);
        bus_read(1'b1, d); check("R1 R6 control reg cleared", d, 8'h40);
    endtask

    task automatic t_pin();
        logic [7:0] d; int n;
        @(negedge clk); ext_pin_n = 1'b0;
        @(negedge clk); check("R2 pin forces reset", sys_rst_n, 0);
        repeat (3) @(negedge clk);
        ext_pin_n = 1'b1;
        count_low(n);
        check("R8 16-cycle stretch", n, 16);
        bus_read(1'b0, d); check("R2 pin flag", d, 8'h01);
    endtask

    task automatic t_mcd();
        logic [7:0] d; int n;
        pulse_mcd();
        expect_quiet("R3 disabled missing clock ignored");
        bus_read(1'b0, d); check("R3 flags unchanged", d, 8'h01);
        bus_write(1'b0, 8'h04);
        pulse_mcd();
        check("R3 enabled missing clock resets", sys_rst_n, 0);
        count_low(n);
        check("R8 stretch after pulse", n, 16);
        bus_read(1'b0, d); check("R3 mcd flag", d, 8'h04);
    endtask

    task automatic t_keep();
        logic [7:0] d; int n;
        pulse_mcd();
        check("R9 enable survives reset", sys_rst_n, 0);
        count_low(n);
        @(negedge clk); ext_pin_n = 1'b0;
        bus_write(1'b0, 8'h00);
        ext_pin_n = 1'b1;
        count_low(n);
        bus_read(1'b0, d); check("R7 pin flag clears mcd flag", d, 8'h01);
        pulse_mcd();
        check("R9 write during reset ignored", sys_rst_n, 0);
        count_low(n);
    endtask

    task automatic t_cmp();
        logic [7:0] d; int n;
        @(negedge clk); cmp_out = 1'b0;
        expect_quiet("R4 disabled comparator ignored");
        cmp_out = 1'b1;
        bus_write(1'b0, 8'h20);
        @(negedge clk); cmp_out = 1'b0;
        @(negedge clk); check("R4 comparator low resets", sys_rst_n, 0);
        @(negedge clk); cmp_out = 1'b1;
        count_low(n);
        bus_read(1'b0, d); check("R4 comparator flag", d, 8'h20);
    endtask

    task automatic t_sup();
        logic [7:0] d; int n;
        bus_write(1'b0, 8'h00);
        sup_low = 1'b1;
        bus_write(1'b1, 8'h80);
        expect_quiet("R5 monitor on but not selected");
        bus_read(1'b1, d); check("R6 status reads below threshold", d, 8'h80);
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'h02);
        expect_quiet("R5 selected but monitor off");
        bus_write(1'b1, 8'h80);
        @(negedge clk); check("R5 both enables reset", sys_rst_n, 0);
        sup_low = 1'b0;
        count_low(n);
        bus_read(1'b0, d); check("R5 supply flag", d, 8'h02);
    endtask

    task automatic t_reserved();
        logic [7:0] d;
        bus_write(1'b1, 8'h3F);
        bus_read(1'b1, d); check("R6 reserved writes ignored", d, 8'h40);
        bus_write(1'b1, 8'hFF);
        bus_read(1'b1, d); check("R6 R10 control readback", d, 8'hC0);
        bus_write(1'b1, 8'h00);
    endtask

    task automatic fire(input logic p, input logic s, input logic m, input logic c);
        int n;
        @(negedge clk);
        ext_pin_n = !p; sup_low = s; clk_missing = m; cmp_out = !c;
        @(negedge clk);
        clk_missing = 1'b0; ext_pin_n = 1'b1; sup_low = 1'b0; cmp_out = 1'b1;
        count_low(n);
    endtask

    task automatic t_prio();
        logic [7:0] d;
        bus_write(1'b0, 8'h26);
        bus_write(1'b1, 8'h80);
        fire(1, 1, 1, 1);
        bus_read(1'b0, d); check("R7 pin wins", d, 8'h01);
        fire(0, 1, 1, 1);
        bus_read(1'b0, d); check("R7 supply beats mcd and comparator", d, 8'h02);
        fire(0, 0, 1, 1);
        bus_read(1'b0, d); check("R7 mcd beats comparator", d, 8'h04);
    endtask

    task automatic t_por2();
        logic [7:0] d; int n;
        @(negedge clk); por_n = 1'b0;
        #3; check("R1 async power-on asserts reset", sys_rst_n, 0);
        @(negedge clk); por_n = 1'b1;
        count_low(n);
        bus_read(1'b0, d); check("R1 flags cleared again", d, 8'h00);
        bus_read(1'b1, d); check("R1 monitor switch cleared", d, 8'h40);
        pulse_mcd();
        expect_quiet("R1 enables cleared by power-on");
    endtask

    initial begin
        t_por();
        t_pin();
        t_mcd();
        t_keep();
        t_cmp();
        t_sup();
        t_reserved();
        t_prio();
        t_por2();
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end
endmodule